// File: doc/BRIEF.md
# Interrupt Entry and Return Controller

This block is the interrupt half of a small processor's control sequencer. The fetch/execute sequencer raises `boundary_i` at the start of each instruction's execution sequence. At that cycle the controller either lets fetch proceed at once, or diverts into a short run of interrupt states. In those states it acknowledges the requesting device and latches the table index that the device drives on the low data lines. It then records the running program counter and privilege mode in a kernel-only context register and enters supervisor mode with interrupts masked. Finally it reads the handler pointer from the vector table at the bottom of memory and loads that pointer into the program counter.

The return instruction is decoded elsewhere and signalled on `rti_i`. It reloads the program counter from the saved context, restores the recorded mode and unmasks interrupts, all without stalling. The sequencer holds `pc_i` steady and waits for `fetch_go_o` whenever the controller reports `busy_o`.

Top module: `irqc_top`

## Requirements
- R1: During and right after synchronous reset, `inta_o`, `busy_o`, `pc_load_o` and `mem_rd_en_o` are 0, the mode is user (`super_mode_o`=0), interrupts are enabled (`int_en_o`=1) and `k0_o` is 0.
- R2: A boundary cycle with `irq_i` low, or with `int_en_o` low, raises `fetch_go_o` in that same cycle, and `inta_o` stays 0 in the following cycle.
- R3: A boundary cycle with `irq_i` high and `int_en_o` high keeps `fetch_go_o` low. `inta_o` is then 1 for exactly the two following cycles and never high together with `fetch_go_o`.
- R4: The index on `dbus_vec_i` is captured in the second acknowledge cycle. In the cycle after acknowledge drops, `mem_rd_en_o` is 1 for one cycle with `mem_addr_o` equal to that index zero-extended, so the table occupies addresses 0 to 2^VEC_BITS-1.
- R5: In that read-request cycle, `pc_i` is stored in the kernel register and is visible on `k0_o` from the next cycle. The mode in force before entry is stored with it.
- R6: From the cycle after the read request, `super_mode_o` is 1 and `int_en_o` is 0.
- R7: The cycle after the read request drives `pc_load_o`=1, `pc_next_o` equal to `mem_rdata_i` (one-cycle read latency) and `fetch_go_o`=1. `busy_o` is 0 from the next cycle on.
- R8: `rti_i` while idle drives `pc_load_o`=1, `pc_next_o`=`k0_o` and `fetch_go_o`=1 in the same cycle. From the next cycle, the mode equals the mode recorded at entry and `int_en_o` is 1.
- R9: While the entry sequence runs (`busy_o`=1), `rti_i`, `boundary_i` and `irq_i` have no effect. No extra PC load occurs, and the sequence completes in supervisor mode with the vector that was latched.
- R10: If `rti_i` and a taken-looking boundary occur in the same idle cycle, the return wins: the PC is restored, `fetch_go_o` is 1 and no acknowledge follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Start of an instruction's execution sequence |
| irq_i | input | 1 | Shared interrupt request line |
| rti_i | input | 1 | Return-from-interrupt instruction is executing |
| dbus_vec_i | input | VEC_BITS | Table index driven by the acknowledged device on the low data lines |
| pc_i | input | AW | Current program counter |
| mem_rdata_i | input | AW | Vector table read data, one cycle after the request |
| inta_o | output | 1 | Interrupt acknowledge to the device chain |
| mem_rd_en_o | output | 1 | Vector table read request |
| mem_addr_o | output | AW | Vector table read address |
| pc_load_o | output | 1 | Load `pc_next_o` into the program counter |
| pc_next_o | output | AW | New program counter value |
| fetch_go_o | output | 1 | Sequencer may start the next fetch |
| busy_o | output | 1 | Entry sequence in progress |
| k0_o | output | AW | Kernel register holding the saved program counter |
| super_mode_o | output | 1 | 1 = supervisor mode, 0 = user mode |
| int_en_o | output | 1 | Interrupt enable flag |

## Verification
The bench builds the controller with a 12-bit program counter and a 3-bit vector index, so the table has eight entries. This makes both the first and the last table slot (indices 0 and 7) reachable in a few directed entries. The narrow counter width also makes a zero-extension or truncation fault on `mem_addr_o` and `pc_next_o` visible. Several entry/return round trips are run with distinct program counters, which separates a kernel register that saves correctly from one that keeps a stale value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACK   = 3'd1,
        ST_LATCH = 3'd2,
        ST_SAVE  = 3'd3,
        ST_LOAD  = 3'd4
    } irqc_state_e;

    typedef enum logic {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } irqc_mode_e;

    // Decision taken in an idle cycle
    typedef struct packed {
        logic take;   // divert into the entry sequence
        logic ret;    // perform a return
        logic pass;   // release the sequencer to fetch now
    } irqc_dec_t;

    function automatic irqc_dec_t irqc_decide(
        input logic idle,
        input logic boundary,
        input logic irq,
        input logic ie,
        input logic rti
    );
        irqc_dec_t d;
        d.take = 1'b0;
        d.ret  = 1'b0;
        d.pass = 1'b0;
        if (idle) begin
            if (rti) begin
                d.ret  = 1'b1;
                d.pass = 1'b1;
            end else if (boundary) begin
                d.take = irq & ie;
                d.pass = ~(irq & ie);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irqc_gate.sv
module irqc_gate
    import irqc_pkg::*;
(
    input  logic      idle_i,
    input  logic      boundary_i,
    input  logic      irq_i,
    input  logic      ie_i,
    input  logic      rti_i,
    output irqc_dec_t dec_o
);

    always_comb begin
        dec_o = irqc_decide(idle_i, boundary_i, irq_i, ie_i, rti_i);
    end

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int AW       = 16,
    parameter int VEC_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  irqc_dec_t           dec_i,
    input  logic [VEC_BITS-1:0] vec_i,
    output irqc_state_e         state_o,
    output logic                inta_o,
    output logic                mem_rd_en_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic                save_o,
    output logic                load_o
);

    localparam int PAD = AW - VEC_BITS;

    irqc_state_e         state_q;
    logic [VEC_BITS-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (dec_i.take) state_q <= ST_ACK;
                ST_ACK:   state_q <= ST_LATCH;
                ST_LATCH: begin
                    vec_q   <= vec_i;
                    state_q <= ST_SAVE;
                end
                ST_SAVE:  state_q <= ST_LOAD;
                ST_LOAD:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        state_o     = state_q;
        inta_o      = (state_q == ST_ACK) || (state_q == ST_LATCH);
        mem_rd_en_o = (state_q == ST_SAVE);
        save_o      = (state_q == ST_SAVE);
        load_o      = (state_q == ST_LOAD);
        mem_addr_o  = {{PAD{1'b0}}, vec_q};
    end

    // R3
    inta_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(inta_o) |=> inta_o);

    // R3
    inta_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(inta_o) |-> ($past(inta_o, 2) && !$past(inta_o, 3)));

    // R4
    rd_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en_o |-> $fell(inta_o));

    // R7
    rd_then_load_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en_o |=> (load_o && !mem_rd_en_o));

endmodule

// File: rtl/irqc_ctx.sv
module irqc_ctx
    import irqc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] pc_i,
    input  logic          save_i,
    input  logic          ret_i,
    output logic [AW-1:0] k0_o,
    output irqc_mode_e    mode_o,
    output logic          ie_o
);

    logic [AW-1:0] k0_q;
    irqc_mode_e    mode_q;
    irqc_mode_e    saved_mode_q;
    logic          ie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            k0_q         <= '0;
            mode_q       <= MODE_USER;
            saved_mode_q <= MODE_USER;
            ie_q         <= 1'b1;
        end else if (save_i) begin
            k0_q         <= pc_i;
            saved_mode_q <= mode_q;
            mode_q       <= MODE_SUPER;
            ie_q         <= 1'b0;
        end else if (ret_i) begin
            mode_q <= saved_mode_q;
            ie_q   <= 1'b1;
        end
    end

    always_comb begin
        k0_o   = k0_q;
        mode_o = mode_q;
        ie_o   = ie_q;
    end

    // R6
    entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
        save_i |=> (mode_o == MODE_SUPER && !ie_o));

    // R5
    k0_capture_chk: assert property (@(posedge clk) disable iff (rst)
        save_i |=> (k0_o == $past(pc_i)));

    // R8
    ret_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> ie_o);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int AW       = 16,
    parameter int VEC_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                boundary_i,
    input  logic                irq_i,
    input  logic                rti_i,
    input  logic [VEC_BITS-1:0] dbus_vec_i,
    input  logic [AW-1:0]       pc_i,
    input  logic [AW-1:0]       mem_rdata_i,
    output logic                inta_o,
    output logic                mem_rd_en_o,
    output logic [AW-1:0]       mem_addr_o,
    output logic                pc_load_o,
    output logic [AW-1:0]       pc_next_o,
    output logic                fetch_go_o,
    output logic                busy_o,
    output logic [AW-1:0]       k0_o,
    output logic                super_mode_o,
    output logic                int_en_o
);

    irqc_dec_t   dec;
    irqc_state_e state;
    irqc_mode_e  mode;
    logic        save_p;
    logic        load_p;
    logic        ie;
    logic [AW-1:0] k0;

    irqc_gate u_gate (
        .idle_i     (state == ST_IDLE),
        .boundary_i (boundary_i),
        .irq_i      (irq_i),
        .ie_i       (ie),
        .rti_i      (rti_i),
        .dec_o      (dec)
    );

    irqc_seq #(.AW(AW), .VEC_BITS(VEC_BITS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .dec_i       (dec),
        .vec_i       (dbus_vec_i),
        .state_o     (state),
        .inta_o      (inta_o),
        .mem_rd_en_o (mem_rd_en_o),
        .mem_addr_o  (mem_addr_o),
        .save_o      (save_p),
        .load_o      (load_p)
    );

    irqc_ctx #(.AW(AW)) u_ctx (
        .clk    (clk),
        .rst    (rst),
        .pc_i   (pc_i),
        .save_i (save_p),
        .ret_i  (dec.ret),
        .k0_o   (k0),
        .mode_o (mode),
        .ie_o   (ie)
    );

    always_comb begin
        pc_load_o    = dec.ret | load_p;
        pc_next_o    = dec.ret ? k0 : mem_rdata_i;
        fetch_go_o   = dec.pass | load_p;
        busy_o       = (state != ST_IDLE);
        k0_o         = k0;
        super_mode_o = (mode == MODE_SUPER);
        int_en_o     = ie;
    end

    // R7
    load_go_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |-> fetch_go_o);

    // R3
    no_go_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_go_o && inta_o));

    // R2
    masked_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && !busy_o && !int_en_o) |-> fetch_go_o);

    // R9
    busy_no_ret_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pc_load_o) |-> (pc_next_o == mem_rdata_i));

endmodule

// File: tb/test_irqc_top.sv
`timescale 1ns/1ps
module test_irqc_top;

    localparam int AW = 12;
    localparam int VB = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          boundary_i, irq_i, rti_i;
    logic [VB-1:0] dbus_vec_i;
    logic [AW-1:0] pc_i, mem_rdata_i;
    logic          inta_o, mem_rd_en_o, pc_load_o, fetch_go_o, busy_o;
    logic          super_mode_o, int_en_o;
    logic [AW-1:0] mem_addr_o, pc_next_o, k0_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irqc_top #(.AW(AW), .VEC_BITS(VB)) i_irqc_top (
        .clk(clk), .rst(rst), .boundary_i(boundary_i), .irq_i(irq_i),
        .rti_i(rti_i), .dbus_vec_i(dbus_vec_i), .pc_i(pc_i),
        .mem_rdata_i(mem_rdata_i), .inta_o(inta_o), .mem_rd_en_o(mem_rd_en_o),
        .mem_addr_o(mem_addr_o), .pc_load_o(pc_load_o), .pc_next_o(pc_next_o),
        .fetch_go_o(fetch_go_o), .busy_o(busy_o), .k0_o(k0_o),
        .super_mode_o(super_mode_o), .int_en_o(int_en_o)
    );

    function automatic logic [AW-1:0] tbl(input logic [AW-1:0] a);
        return AW'(12'h3C0 ^ (a * 12'h111) ^ 12'h005);
    endfunction

    // Vector table memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en_o) mem_rdata_i <= tbl(mem_addr_o);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 inta", inta_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 pc_load", pc_load_o, 0);
        chk("R1 rd_en", mem_rd_en_o, 0);
        chk("R1 mode", super_mode_o, 0);
        chk("R1 ie", int_en_o, 1);
        chk("R1 k0", k0_o, 0);
    endtask

    task automatic t_no_irq();
        @(negedge clk);
        boundary_i = 1; irq_i = 0;
        #1;
        chk("R2 go no irq", fetch_go_o, 1);
        step();
        boundary_i = 0;
        #1;
        chk("R2 no ack", inta_o, 0);
        chk("R2 idle", busy_o, 0);
    endtask

    task automatic t_entry(input logic [AW-1:0] pc, input logic [VB-1:0] vec,
                           input bit disturb);
        logic old_mode;
        old_mode = super_mode_o;
        @(negedge clk);
        boundary_i = 1; irq_i = 1; pc_i = pc; dbus_vec_i = '0;
        #1;
        chk("R3 no go on take", fetch_go_o, 0);
        chk("R3 no ack yet", inta_o, 0);
        @(negedge clk);
        boundary_i = 0; dbus_vec_i = vec;
        if (disturb) begin rti_i = 1; boundary_i = 1; end
        #1;
        chk("R3 ack 1", inta_o, 1);
        chk("R3 busy", busy_o, 1);
        if (disturb) chk("R9 rti ignored", pc_load_o, 0);
        @(negedge clk);
        rti_i = 0; boundary_i = 0;
        #1;
        chk("R3 ack 2", inta_o, 1);
        @(negedge clk);
        dbus_vec_i = ~vec; irq_i = 0;
        #1;
        chk("R3 ack dropped", inta_o, 0);
        chk("R4 rd_en", mem_rd_en_o, 1);
        chk("R4 addr", mem_addr_o, {{(AW-VB){1'b0}}, vec});
        chk("R6 mode before", super_mode_o, old_mode);
        step();
        chk("R7 pc_load", pc_load_o, 1);
        chk("R7 pc_next", pc_next_o, tbl({{(AW-VB){1'b0}}, vec}));
        chk("R7 go", fetch_go_o, 1);
        chk("R5 k0", k0_o, pc);
        chk("R6 super", super_mode_o, 1);
        chk("R6 ie off", int_en_o, 0);
        chk("R4 rd one cycle", mem_rd_en_o, 0);
        step();
        chk("R7 released", busy_o, 0);
        chk("R7 single load", pc_load_o, 0);
        if (disturb) chk("R9 still super", super_mode_o, 1);
    endtask

    task automatic t_masked();
        @(negedge clk);
        boundary_i = 1; irq_i = 1;
        #1;
        chk("R2 masked go", fetch_go_o, 1);
        @(negedge clk);
        boundary_i = 0; irq_i = 0;
        #1;
        chk("R2 masked no ack", inta_o, 0);
    endtask

    task automatic t_rti(input logic [AW-1:0] exp_pc, input bit with_boundary);
        @(negedge clk);
        rti_i = 1;
        if (with_boundary) begin boundary_i = 1; irq_i = 1; end
        #1;
        chk(with_boundary ? "R10 load" : "R8 load", pc_load_o, 1);
        chk(with_boundary ? "R10 pc" : "R8 pc", pc_next_o, exp_pc);
        chk(with_boundary ? "R10 go" : "R8 go", fetch_go_o, 1);
        @(negedge clk);
        rti_i = 0; boundary_i = 0; irq_i = 0;
        #1;
        chk("R8 mode restored", super_mode_o, 0);
        chk("R8 ie on", int_en_o, 1);
        if (with_boundary) chk("R10 no ack", inta_o, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1; boundary_i = 0; irq_i = 0; rti_i = 0;
        dbus_vec_i = '0; pc_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        t_reset();
        rst = 0;
        step();
        t_reset();
        t_no_irq();
        t_entry(12'h123, 3'd5, 1'b0);
        t_masked();
        t_rti(12'h123, 1'b0);
        t_entry(12'h456, 3'd0, 1'b1);
        t_rti(12'h456, 1'b1);
        t_entry(12'h7FF, 3'd7, 1'b0);
        t_rti(12'h7FF, 1'b0);
        t_no_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule